// File: doc/BRIEF.md
# Cumulative DRAM Row Decoder

This block maps a host physical byte address onto one of eight DRAM rows. Each row is given a boundary: a running total, in megabytes, of all memory in that row and every row below it. The row that owns an address is the lowest row whose boundary lies above the address's megabyte number. The boundary of the last row is therefore the total amount of DRAM installed.

Each 8-bit boundary byte is widened by a 4-bit extension nibble. Only the lowest ten bits of the combined value take part in decoding. A programmable memory hole can also be placed low in the address space. Its size is a power of two and its bottom is aligned to that size. An address inside an enabled hole, or at or beyond the total, is not decoded to DRAM and is flagged to be forwarded to PCI instead.

A byte-wide register port writes and reads back the boundaries, the extension nibbles and the two hole-control bytes. A request strobe with an address produces a registered result on the next clock.

Top module: `drow_decoder`

## Requirements
- R1: Register addresses 0 to 7 hold the boundary bytes of rows 0 to 7. A write stores the byte and a read returns it.
- R2: Register addresses 8 to 11 hold the extension nibbles, two rows per byte: the even row in bits 3-0 and the odd row in bits 7-4. All four nibble bits read back, but a row's decode boundary is {nibble bits 1-0, boundary byte}, ten bits in MB. Nibble bits 3-2 have no effect on decoding.
- R3: For a request, the address megabyte is req_addr[31:20]. The selected row is the lowest row whose decode boundary is greater than that megabyte, and it is reported as one-hot bit i of out_row.
- R4: A row whose boundary equals the boundary of the row below it holds no memory and is never selected.
- R5: A megabyte at or above the row-7 boundary sets out_pci and leaves out_row zero.
- R6: Register 13 bit 7 enables the hole, and bits 6-4 give the hole size in MB minus one. Register 12 bits 7-4 give the hole bottom in MB. While the hole is enabled, a megabyte in [bottom, bottom+size) sets out_pci with out_row zero, overriding the row decode.
- R7: When out_valid is high, exactly one of the following holds: out_pci is set, or out_row has exactly one bit set.
- R8: out_valid rises exactly one clock after a cycle with req_valid high and is low otherwise. When out_valid is low, out_row and out_pci are zero.
- R9: Bits 3-0 of registers 12 and 13 are reserved. They read as zero and ignore written values.
- R10: After reset every register reads zero and out_valid is low. With all boundaries zero, every request is forwarded to PCI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| req_valid | input | 1 | Decode request strobe |
| req_addr | input | 32 | Host physical byte address |
| out_valid | output | 1 | Decode result valid |
| out_row | output | 8 | One-hot selected row |
| out_pci | output | 1 | Access is forwarded to PCI |

## Verification
The assertions assume that software programs the boundaries as a non-decreasing sequence. They also assume that the hole size is a power of two and that its bottom is a multiple of that size. The one-hot and exclusivity properties are only meaningful under these conditions. The stimulus keeps to them by writing cumulative boundary sets, including a repeated value for an empty row, and by programming only aligned power-of-two holes. The reserved-bit write of all ones to the hole-size byte is the single case that breaks the alignment rule. That hole is still contiguous and decoded by range, so the bench model predicts it the same way.

// File: rtl/drow_pkg.sv
package drow_pkg;

    localparam int DR_ROWS   = 8;
    localparam int DR_BYTE_W = 8;
    localparam int DR_EXT_W  = 4;
    localparam int DR_USE_W  = 10;

    typedef struct packed {
        logic       en;
        logic [2:0] size_m1;
        logic [3:0] bottom;
    } gap_t;

    // hole size in MB from its encoded field
    function automatic logic [3:0] hole_size(input logic [2:0] size_m1);
        return {1'b0, size_m1} + 4'd1;
    endfunction

    // isolate the lowest set bit of a vector
    function automatic logic [DR_ROWS-1:0] lowest_bit(input logic [DR_ROWS-1:0] v);
        return v & (~v + DR_ROWS'(1));
    endfunction

endpackage

// File: rtl/drow_regs.sv
module drow_regs
    import drow_pkg::*;
#(
    parameter int ROWS   = DR_ROWS,
    parameter int BYTE_W = DR_BYTE_W,
    parameter int EXT_W  = DR_EXT_W,
    parameter int USE_W  = DR_USE_W,
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [USE_W-1:0]  bound_o [ROWS],
    output gap_t              gap_o
);
    localparam int EXT_REGS = ROWS / 2;
    localparam int GAP_LO   = ROWS + EXT_REGS;
    localparam int GAP_HI   = GAP_LO + 1;

    logic [BYTE_W-1:0] bnd_q [ROWS];
    logic [EXT_W-1:0]  ext_q [ROWS];
    gap_t              gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ROWS; i++) begin
                bnd_q[i] <= '0;
                ext_q[i] <= '0;
            end
            gap_q <= '0;
        end else if (we) begin
            for (int i = 0; i < ROWS; i++) begin
                if (addr == REG_AW'(i)) bnd_q[i] <= wdata;
            end
            for (int j = 0; j < EXT_REGS; j++) begin
                if (addr == REG_AW'(ROWS + j)) begin
                    ext_q[2*j]   <= wdata[EXT_W-1:0];
                    ext_q[2*j+1] <= wdata[2*EXT_W-1:EXT_W];
                end
            end
            if (addr == REG_AW'(GAP_LO)) gap_q.bottom <= wdata[7:4];
            if (addr == REG_AW'(GAP_HI)) begin
                gap_q.en      <= wdata[7];
                gap_q.size_m1 <= wdata[6:4];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < ROWS; i++) begin
            if (addr == REG_AW'(i)) rdata = bnd_q[i];
        end
        for (int j = 0; j < EXT_REGS; j++) begin
            if (addr == REG_AW'(ROWS + j)) rdata = {ext_q[2*j+1], ext_q[2*j]};
        end
        if (addr == REG_AW'(GAP_LO)) rdata = {gap_q.bottom, 4'h0};
        if (addr == REG_AW'(GAP_HI)) rdata = {gap_q.en, gap_q.size_m1, 4'h0};
    end

    for (genvar g = 0; g < ROWS; g++) begin : g_bound
        assign bound_o[g] = USE_W'({ext_q[g], bnd_q[g]});
    end

    assign gap_o = gap_q;

endmodule

// File: rtl/drow_hole.sv
module drow_hole
    import drow_pkg::*;
#(
    parameter int MB_W = 12
) (
    input  gap_t            gap,
    input  logic [MB_W-1:0] mb,
    output logic            hit
);
    logic [MB_W-1:0] lo;
    logic [MB_W-1:0] hi;

    assign lo  = MB_W'(gap.bottom);
    assign hi  = lo + MB_W'(hole_size(gap.size_m1));
    assign hit = gap.en && (mb >= lo) && (mb < hi);

endmodule

// File: rtl/drow_rowsel.sv
module drow_rowsel
    import drow_pkg::*;
#(
    parameter int ROWS  = DR_ROWS,
    parameter int USE_W = DR_USE_W,
    parameter int MB_W  = 12
) (
    input  logic [USE_W-1:0] bound [ROWS],
    input  logic [MB_W-1:0]  mb,
    output logic [ROWS-1:0]  row,
    output logic             beyond
);
    logic [ROWS-1:0] above;

    for (genvar g = 0; g < ROWS; g++) begin : g_cmp
        assign above[g] = MB_W'(bound[g]) > mb;
    end

    assign row    = lowest_bit(above);
    assign beyond = ~above[ROWS-1];

endmodule

// File: rtl/drow_decoder.sv
module drow_decoder
    import drow_pkg::*;
#(
    parameter int ROWS     = DR_ROWS,
    parameter int ADDR_W   = 32,
    parameter int MB_SHIFT = 20,
    parameter int USE_W    = DR_USE_W,
    parameter int REG_AW   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              out_valid,
    output logic [ROWS-1:0]   out_row,
    output logic              out_pci
);
    localparam int MB_W = ADDR_W - MB_SHIFT;

    logic [USE_W-1:0] bound_w [ROWS];
    gap_t             gap_w;
    logic [MB_W-1:0]  req_mb;
    logic [ROWS-1:0]  row_w;
    logic             beyond_w;
    logic             hole_w;
    logic             pci_d;

    assign req_mb = req_addr[ADDR_W-1:MB_SHIFT];

    drow_regs #(
        .ROWS(ROWS), .BYTE_W(8), .EXT_W(4), .USE_W(USE_W), .REG_AW(REG_AW)
    ) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .bound_o(bound_w), .gap_o(gap_w)
    );

    drow_rowsel #(.ROWS(ROWS), .USE_W(USE_W), .MB_W(MB_W)) u_sel (
        .bound(bound_w), .mb(req_mb), .row(row_w), .beyond(beyond_w)
    );

    drow_hole #(.MB_W(MB_W)) u_hole (
        .gap(gap_w), .mb(req_mb), .hit(hole_w)
    );

    assign pci_d = beyond_w | hole_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_row   <= '0;
            out_pci   <= 1'b0;
        end else begin
            out_valid <= req_valid;
            out_row   <= (req_valid && !pci_d) ? row_w : '0;
            out_pci   <= req_valid && pci_d;
        end
    end

endmodule

// File: rtl/drow_decoder_chk.sv
module drow_decoder_chk #(
    parameter int ROWS   = 8,
    parameter int MB_W   = 12,
    parameter int USE_W  = 10,
    parameter int REG_AW = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [MB_W-1:0]   mb,
    input logic [USE_W-1:0]  total,
    input logic              hole_hit,
    input logic [REG_AW-1:0] reg_addr,
    input logic [7:0]        reg_rdata,
    input logic              out_valid,
    input logic [ROWS-1:0]   out_row,
    input logic              out_pci
);
    localparam int GAP_LO = ROWS + ROWS / 2;

    p_row_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_pci ? (out_row == '0) : ($countones(out_row) == 1)));

    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_row == '0 && !out_pci));

    p_beyond_pci_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mb >= MB_W'(total)) |=> out_pci);

    p_hole_pci_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && hole_hit) |=> out_pci);

    p_gap_resv_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == REG_AW'(GAP_LO) || reg_addr == REG_AW'(GAP_LO + 1))
            |-> (reg_rdata[3:0] == 4'h0));

endmodule

bind drow_decoder drow_decoder_chk #(
    .ROWS(ROWS), .MB_W(MB_W), .USE_W(USE_W), .REG_AW(REG_AW)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .mb(req_mb),
    .total(bound_w[ROWS-1]), .hole_hit(hole_w), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .out_valid(out_valid), .out_row(out_row),
    .out_pci(out_pci)
);

// File: tb/drow_decoder_tb.sv
module drow_decoder_tb;

    typedef struct {
        logic [7:0] row;
        logic       pci;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        out_valid;
    logic [7:0]  out_row;
    logic        out_pci;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    exp_t sb [$];

    // bench copy of programmed state
    logic [7:0] m_bnd [8];
    logic [3:0] m_ext [8];
    logic       m_en;
    logic [2:0] m_sz;
    logic [3:0] m_bot;

    always #10 clk = ~clk;

    drow_decoder u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .out_valid(out_valid), .out_row(out_row),
        .out_pci(out_pci)
    );

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected < 20000)", cycles);
            finish_run();
        end
    end

    // monitor: pop and compare
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                checks++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL R8: unexpected result row=%h pci=%b (expected none)", out_row, out_pci);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (out_row !== e.row || out_pci !== e.pci) begin
                        errors++;
                        $display("FAIL %s: row=%h pci=%b expected row=%h pci=%b",
                                 e.tag, out_row, out_pci, e.row, e.pci);
                    end
                end
            end else if (out_row !== 8'h0 || out_pci !== 1'b0) begin
                checks++; errors++;
                $display("FAIL R8: idle outputs row=%h pci=%b expected 00/0", out_row, out_pci);
            end
        end
    end

    function automatic exp_t model(input logic [31:0] a, input string tag);
        exp_t e;
        logic [11:0] mb = a[31:20];
        logic [11:0] lo = {8'h0, m_bot};
        logic [11:0] hi = lo + {9'h0, m_sz} + 12'd1;
        logic [11:0] b;
        e.row = '0; e.pci = 1'b0; e.tag = tag;
        if (m_en && mb >= lo && mb < hi) begin
            e.pci = 1'b1;
            return e;
        end
        for (int i = 0; i < 8; i++) begin
            b = {2'b00, m_ext[i][1:0], m_bnd[i]};
            if (b > mb) begin
                e.row[i] = 1'b1;
                return e;
            end
        end
        e.pci = 1'b1;
        return e;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b0;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        if (a < 8) m_bnd[a] = d;
        else if (a < 12) begin
            m_ext[2*(a-8)] = d[3:0];
            m_ext[2*(a-8)+1] = d[7:4];
        end else if (a == 12) m_bot = d[7:4];
        else if (a == 13) begin m_en = d[7]; m_sz = d[6:4]; end
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input logic [3:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_we = 1'b0; req_valid = 1'b0; reg_addr = a;
        #2;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s: reg %0d read %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic req(input logic [31:0] a, input string tag);
        @(negedge clk);
        reg_we = 1'b0;
        req_valid = 1'b1; req_addr = a;
        sb.push_back(model(a, tag));
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; reg_we = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin m_bnd[i] = '0; m_ext[i] = '0; end
        m_en = 1'b0; m_sz = '0; m_bot = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        checks++;
        if (out_valid !== 1'b0) begin
            errors++; $display("FAIL R10: out_valid=%b expected 0", out_valid);
        end
        for (int i = 0; i < 14; i++) rd_check(4'(i), 8'h00, "R10");
        req(32'h0000_0000, "R10");
        req(32'h1234_5678, "R10");
        idle();

        // R1 / R2 program cumulative boundaries: 4,8,8,16,32,64,300,300 MB
        wr(0, 8'd4);  wr(1, 8'd8);  wr(2, 8'd8);  wr(3, 8'd16);
        wr(4, 8'd32); wr(5, 8'd64); wr(6, 8'h2C); wr(7, 8'h2C);
        wr(11, 8'h1D);   // row6 nibble D (bits3-2 ignored), row7 nibble 1
        rd_check(3, 8'd16, "R1");
        rd_check(6, 8'h2C, "R1");
        rd_check(11, 8'h1D, "R2");

        // R3 row select, back to back
        req(32'h0000_0000, "R3");
        req(32'h003F_FFFF, "R3");
        req(32'h0040_0000, "R3");
        req(32'h0200_0000, "R3");
        req(32'h12B0_0000, "R2");   // 299 MB -> row6 using extension
        // R4 empty row 2 skipped
        req(32'h0080_0000, "R4");
        req(32'h00FF_FFFF, "R4");
        // R5 beyond total
        req(32'h12C0_0000, "R5");
        req(32'hFFFF_FFFF, "R5");
        idle();

        // R6 hole of 2 MB at 14 MB
        wr(12, 8'hE0); wr(13, 8'h90);
        req(32'h00D0_0000, "R6");
        req(32'h00E0_0000, "R6");
        req(32'h00F8_0000, "R6");
        req(32'h0100_0000, "R6");
        idle();
        wr(13, 8'h10);  // disable
        req(32'h00E0_0000, "R6");
        idle();

        // R9 reserved bits
        wr(12, 8'hFF); wr(13, 8'hFF);
        rd_check(12, 8'hF0, "R9");
        rd_check(13, 8'hF0, "R9");
        req(32'h0140_0000, "R9");   // 20 MB in hole [15,23)
        req(32'h0170_0000, "R9");   // 23 MB -> row4
        idle();
        wr(13, 8'h00);

        // R7 mixed pattern
        for (int k = 0; k < 40; k++) req({k[7:0], 24'h00_0000} >> 1, "R7");
        idle();

        repeat (4) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R8: %0d results missing, expected 0", sb.size());
        end
        finish_run();
    end

endmodule